// File: doc/BRIEF.md
# Vector Operand Swizzle and Write-Mask Unit

This block sits in front of a four-lane vector ALU whose lanes are 32 bits wide, so one register holds 128 bits. For each of its two source operands it reorders the components lane by lane. Each destination lane names which source component it takes. Any component may feed several lanes, and a lane may instead take one of four fixed constant bit patterns. The routed operands then go through one of four integer operations: a per-lane multiply-accumulate into the old destination, a four-term dot product, a three-term dot product, or a plain move of the routed first operand.

A per-lane write mask merges the operation result with the old destination value before the result register, so a disabled lane returns its old contents unchanged. Results appear one clock after an accepted input and carry a matching valid flag. Lanes use wrapping 32-bit integer arithmetic. The constants are not converted: they pass through as raw bits, which lets routing, constant insertion and masking be checked exactly.

Top module: `vswz_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_data` are cleared to zero.
- R2: `out_valid` equals `in_valid` from the previous clock. While `in_valid` is low, `out_data` keeps its value.
- R3: Lane i occupies bits [32i+31:32i], with lane 0 as X. A swizzle code of 0 to 3 in bits [3i+2:3i] of `swz_a` or `swz_b` makes operand lane i take source component X, Y, Z or W. One component may feed several lanes.
- R4: Swizzle codes 4, 5, 6 and 7 make the operand lane take the constants 0x00000000, 0x3F800000, 0x40000000 and 0x3F000000.
- R5: With `op`=0, each lane result is routedA × routedB + old destination lane, modulo 2^32.
- R6: With `op`=1, the modulo-2^32 sum of all four lane products is written to every lane.
- R7: With `op`=2, the sum of the X, Y and Z lane products is written to every lane, and the W components have no effect.
- R8: With `op`=3, each lane result is the routed first operand.
- R9: Bit i of `wr_mask` set to 0 makes result lane i equal the old destination lane i, for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 2 | Operation: 0 multiply-accumulate, 1 four-term dot, 2 three-term dot, 3 move |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| dst_old | input | 128 | Current destination value, used for masked lanes and as the accumulator |
| swz_a | input | 12 | Per-lane 3-bit selector for the first source |
| swz_b | input | 12 | Per-lane 3-bit selector for the second source |
| wr_mask | input | 4 | Per-lane write enable |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Registered result vector |

## Verification
The dot-product broadcast and the write mask act in the same cycle. A broadcast scalar must land only in enabled lanes, while the other lanes return the old destination. The bench provokes this by issuing dot products with partial masks, with reordered operands and with constants swizzled into operands. It compares every lane against a reference model that builds the routed operands, the scalar and the merge on its own.

// File: rtl/vswz_pkg.sv
// Package: shared widths, operation codes and the constant table for the
// vector swizzle unit. Assumes a fixed four-lane, 32-bit-lane organisation.
package vswz_pkg;
    parameter int NL    = 4;
    parameter int LW    = 32;
    parameter int SELW  = 3;
    parameter int VW    = NL * LW;
    parameter int SWZW  = NL * SELW;

    typedef enum logic [1:0] {
        OP_MAD = 2'd0,
        OP_DP4 = 2'd1,
        OP_DP3 = 2'd2,
        OP_MOV = 2'd3
    } vop_e;

    // Bit pattern for constant selector index 0..3 (zero, one, two, half).
    function automatic logic [LW-1:0] const_bits(input logic [1:0] idx);
        logic [LW-1:0] v;
        case (idx)
            2'd0:    v = 32'h0000_0000;
            2'd1:    v = 32'h3F80_0000;
            2'd2:    v = 32'h4000_0000;
            default: v = 32'h3F00_0000;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/vswz_sel.sv
// Module: one lane of operand routing. Picks a source component by index
// or a fixed constant when the top selector bit is set.
// Assumes NL == 4 so that two selector bits address a component.
module vswz_sel
    import vswz_pkg::*;
#(
    parameter int LANE_W = LW,
    parameter int LANES  = NL
) (
    input  logic [LANES*LANE_W-1:0] vec,
    input  logic [SELW-1:0]         code,
    output logic [LANE_W-1:0]       lane
);
    // Route a component or substitute a constant.
    always_comb begin
        if (code[SELW-1])
            lane = const_bits(code[1:0]);
        else
            lane = vec[code[1:0]*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/vswz_alu.sv
// Module: integer lane arithmetic on routed operands. Produces per-lane
// multiply-accumulate, broadcast dot products (4 or 3 terms) or a move.
// Assumes wrapping arithmetic at the lane width.
module vswz_alu
    import vswz_pkg::*;
#(
    parameter int LANE_W = LW,
    parameter int LANES  = NL
) (
    input  vop_e                    op,
    input  logic [LANES*LANE_W-1:0] opa,
    input  logic [LANES*LANE_W-1:0] opb,
    input  logic [LANES*LANE_W-1:0] acc,
    output logic [LANES*LANE_W-1:0] res
);
    logic [LANE_W-1:0] prod [LANES];
    logic [LANE_W-1:0] dot;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_mul
            // Per-lane product, truncated to the lane width.
            always_comb prod[g] = opa[g*LANE_W +: LANE_W] * opb[g*LANE_W +: LANE_W];
        end
    endgenerate

    // Reduce products; the three-term form leaves out the last lane.
    always_comb begin
        dot = '0;
        for (int i = 0; i < LANES; i++)
            if (op == OP_DP4 || i < LANES - 1)
                dot = dot + prod[i];
    end

    // Select the per-lane result for the requested operation.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            case (op)
                OP_MAD:  res[i*LANE_W +: LANE_W] = prod[i] + acc[i*LANE_W +: LANE_W];
                OP_MOV:  res[i*LANE_W +: LANE_W] = opa[i*LANE_W +: LANE_W];
                default: res[i*LANE_W +: LANE_W] = dot;
            endcase
        end
    end
endmodule

// File: rtl/vswz_wmask.sv
// Module: write-mask merge and result register. Disabled lanes keep the
// old destination; the register loads only on valid input.
// Assumes synchronous active-low reset.
module vswz_wmask
    import vswz_pkg::*;
#(
    parameter int LANE_W = LW,
    parameter int LANES  = NL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*LANE_W-1:0] new_vec,
    input  logic [LANES*LANE_W-1:0] old_vec,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_vec
);
    logic [LANES*LANE_W-1:0] merged;

    // Per-lane choice between new result and old destination.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            merged[i*LANE_W +: LANE_W] = mask[i] ? new_vec[i*LANE_W +: LANE_W]
                                                 : old_vec[i*LANE_W +: LANE_W];
    end

    // Result and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_vec <= merged;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_chk
            // R9
            masked_lane_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mask[g]) |=>
                    out_vec[g*LANE_W +: LANE_W] == $past(old_vec[g*LANE_W +: LANE_W]));
        end
    endgenerate
endmodule

// File: rtl/vswz_unit.sv
// Module: top of the vector operand swizzle and write-mask unit. Routes
// both sources per lane, runs the lane arithmetic and registers the
// masked result one cycle after a valid input.
// Assumes four 32-bit lanes and synchronous active-low reset.
module vswz_unit
    import vswz_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic [VW-1:0]   src_a,
    input  logic [VW-1:0]   src_b,
    input  logic [VW-1:0]   dst_old,
    input  logic [SWZW-1:0] swz_a,
    input  logic [SWZW-1:0] swz_b,
    input  logic [NL-1:0]   wr_mask,
    output logic            out_valid,
    output logic [VW-1:0]   out_data
);
    logic [VW-1:0] opa, opb, alu_res;
    vop_e          op_e;

    // Cast the raw opcode to the operation type.
    always_comb op_e = vop_e'(op);

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lane
            vswz_sel #(.LANE_W(LW), .LANES(NL)) i_sel_a (
                .vec (src_a),
                .code(swz_a[g*SELW +: SELW]),
                .lane(opa[g*LW +: LW])
            );
            vswz_sel #(.LANE_W(LW), .LANES(NL)) i_sel_b (
                .vec (src_b),
                .code(swz_b[g*SELW +: SELW]),
                .lane(opb[g*LW +: LW])
            );
        end
    endgenerate

    vswz_alu #(.LANE_W(LW), .LANES(NL)) i_alu (
        .op (op_e),
        .opa(opa),
        .opb(opb),
        .acc(dst_old),
        .res(alu_res)
    );

    vswz_wmask #(.LANE_W(LW), .LANES(NL)) i_wmask (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mask     (wr_mask),
        .new_vec  (alu_res),
        .old_vec  (dst_old),
        .out_valid(out_valid),
        .out_vec  (out_data)
    );

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));
    // R4
    const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd3 && swz_a[2:0] == 3'd5 && wr_mask[0]) |=>
            out_data[31:0] == 32'h3F80_0000);
    // R6
    dot_broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd1 && wr_mask == 4'hF) |=>
            (out_data[31:0] == out_data[63:32] && out_data[63:32] == out_data[95:64]
             && out_data[95:64] == out_data[127:96]));
endmodule

// File: tb/test_vswz_unit.sv
// Scoreboard bench: the driver pushes model results, the monitor pops and
// compares them whenever the unit presents a valid result.
module test_vswz_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [127:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [11:0]  swz_a = '0, swz_b = '0;
    logic [3:0]   wr_mask = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [127:0] data;
        string        tag;
    } item_t;
    item_t sb[$];
    logic [127:0] last_exp = '0;

    always #5 clk = ~clk;

    vswz_unit i_vswz_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .swz_a(swz_a), .swz_b(swz_b), .wr_mask(wr_mask),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] pick(input logic [127:0] v, input logic [2:0] c);
        case (c)
            3'd4: return 32'h0000_0000;
            3'd5: return 32'h3F80_0000;
            3'd6: return 32'h4000_0000;
            3'd7: return 32'h3F00_0000;
            default: return v[c*32 +: 32];
        endcase
    endfunction

    function automatic logic [127:0] model(input logic [1:0] o, input logic [127:0] a,
        input logic [127:0] b, input logic [127:0] d, input logic [11:0] sa,
        input logic [11:0] sb_, input logic [3:0] m);
        logic [31:0] ra [4];
        logic [31:0] rb [4];
        logic [31:0] r, s3, s4;
        logic [127:0] out;
        for (int i = 0; i < 4; i++) begin
            ra[i] = pick(a, sa[i*3 +: 3]);
            rb[i] = pick(b, sb_[i*3 +: 3]);
        end
        s3 = ra[0]*rb[0] + ra[1]*rb[1] + ra[2]*rb[2];
        s4 = s3 + ra[3]*rb[3];
        for (int i = 0; i < 4; i++) begin
            case (o)
                2'd0: r = ra[i]*rb[i] + d[i*32 +: 32];
                2'd1: r = s4;
                2'd2: r = s3;
                default: r = ra[i];
            endcase
            out[i*32 +: 32] = m[i] ? r : d[i*32 +: 32];
        end
        return out;
    endfunction

    task automatic send(input string tag, input logic [1:0] o, input logic [127:0] a,
        input logic [127:0] b, input logic [127:0] d, input logic [11:0] sa,
        input logic [11:0] sbz, input logic [3:0] m);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; op = o; src_a = a; src_b = b; dst_old = d;
        swz_a = sa; swz_b = sbz; wr_mask = m;
        it.data = model(o, a, b, d, sa, sbz, m);
        it.tag  = tag;
        last_exp = it.data;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a = ~src_a; dst_old = ~dst_old;
        end
    endtask

    // Monitor: compare presented results against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected out_valid, data=%h expected none", out_data);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (out_data !== it.data) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, out_data, it.data);
                end
            end
        end
    end

    localparam logic [11:0] IDN = {3'd3, 3'd2, 3'd1, 3'd0};
    logic [127:0] va = {32'd4, 32'd3, 32'd2, 32'd1};
    logic [127:0] vb = {32'd8, 32'd7, 32'd6, 32'd5};
    logic [127:0] vd = {32'hDDDD_0003, 32'hDDDD_0002, 32'hDDDD_0001, 32'hDDDD_0000};

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1: got v=%b d=%h expected v=0 d=0", out_valid, out_data);
        end
        rst_n = 1'b1;
        send("R5 mad identity", 2'd0, va, vb, vd, IDN, IDN, 4'hF);
        send("R3 reversed move", 2'd3, va, vb, vd, {3'd0, 3'd1, 3'd2, 3'd3}, IDN, 4'hF);
        send("R3 duplicated components", 2'd0, va, vb, vd, {3'd1, 3'd1, 3'd0, 3'd0},
             {3'd2, 3'd2, 3'd2, 3'd2}, 4'hF);
        send("R4 constants move", 2'd3, va, vb, vd, {3'd7, 3'd6, 3'd5, 3'd4}, IDN, 4'hF);
        send("R6 dot4 broadcast", 2'd1, va, vb, vd, IDN, IDN, 4'hF);
        send("R7 dot3 ignores W", 2'd2, {32'hFFFF_0000, va[95:0]},
             {32'h1234_5678, vb[95:0]}, vd, IDN, IDN, 4'hF);
        send("R9 mad partial mask", 2'd0, va, vb, vd, IDN, IDN, 4'b0101);
        send("R9 dot4 masked swizzled", 2'd1, va, vb, vd, {3'd0, 3'd3, 3'd1, 3'd2},
             {3'd6, 3'd0, 3'd3, 3'd3}, 4'b1000);
        idle(1);
        send("R9 all lanes masked", 2'd1, va, vb, vd, IDN, IDN, 4'h0);
        send("R5 wraparound", 2'd0, {4{32'hFFFF_FFFF}}, {4{32'h0000_0002}},
             {4{32'h0000_0005}}, IDN, IDN, 4'hF);
        send("R4 constants into mad", 2'd0, va, vb, vd, IDN, {3'd7, 3'd6, 3'd5, 3'd4}, 4'hF);
        send("R8 move identity", 2'd3, va, vb, vd, IDN, {3'd4, 3'd4, 3'd4, 3'd4}, 4'hF);
        send("R7 dot3 partial mask", 2'd2, va, vb, vd, {3'd5, 3'd2, 3'd1, 3'd0},
             IDN, 4'b0110);
        idle(3);
        checks++;
        if (out_valid !== 1'b0 || out_data !== last_exp) begin
            errors++;
            $display("FAIL R2: idle got v=%b d=%h expected v=0 d=%h",
                     out_valid, out_data, last_exp);
        end
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule